// File: doc/BRIEF.md
# Sum of Absolute Differences Engine

This block walks two byte arrays held in external synchronous memories and totals the absolute difference of every element pair. A single control input starts a pass; the block then clears its running total and element counter, reads one pair per iteration through a shared address port, and adds the magnitude of each pair's difference to the total. When every pair has been consumed the total is copied into a result register and a one-cycle completion strobe is raised.

A small multi-state controller sequences the work: it waits for the start input, initialises, tests the counter against the array length, accumulates, and finally publishes the result before waiting again. The counter doubles as the memory address. Because the memories answer one cycle after the address is presented, the test state presents the address and the accumulate state consumes the data, so each pair takes two cycles.

Top module: `sad_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `sad` is 0 and `done` is 0.
- R2: While idle with `start` low, the block stays idle: `done` stays 0 and `sad` keeps its value.
- R3: After a pass, `sad` equals the sum over i of |A[i] − B[i]| for all DEPTH pairs, with both bytes unsigned.
- R4: `done` rises exactly 2·DEPTH+4 rising edges after the edge that samples `start` high in the idle state, counting that edge as the first.
- R5: `done` is high for exactly one cycle per pass, and `sad` changes only in the cycle `done` is high.
- R6: Changes on `start` while a pass is running have no effect on the result or its timing.
- R7: The total does not wrap: all-255 against all-0 arrays give 65280 with the default 16-bit result.
- R8: With `start` held high, a new pass begins at once after the previous one, so successive `done` pulses are 2·DEPTH+4 cycles apart.
- R9: Each pass begins from a total of zero; a result never includes a previous pass.
- R10: `mem_addr` equals the element index, and the data on `a_rdata`/`b_rdata` is expected one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass when sampled high in the idle state |
| mem_addr | output | AW | Element index presented to both memories |
| a_rdata | input | DW | Byte from the first array, one cycle after the address |
| b_rdata | input | DW | Byte from the second array, one cycle after the address |
| sad | output | SUM_W | Result of the most recent completed pass |
| done | output | 1 | One-cycle strobe when `sad` is updated |

## Verification
The bench sweeps every possible pair of byte values across 256 passes, so an absolute difference that used the wrong operand order or signed arithmetic shows up as a wrong total. All-equal and all-extreme arrays probe the zero result and the largest total, which a narrow accumulator would wrap. Every pass is timed from the start edge, exposing a controller that skips the read-latency cycle or runs one element too many or too few, and back-to-back passes with different data catch a total that is not cleared. Toggling `start` mid-pass and holding it high check that the request is ignored while busy yet honoured immediately once idle.

// File: rtl/sad_engine.sv
module sad_engine #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int SUM_W = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    a_rdata,
  input  logic [DW-1:0]    b_rdata,
  output logic [SUM_W-1:0] sad,
  output logic             done
);
  localparam int IW = AW + 1;

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_TEST, S_ACC, S_RES} st_t;
  st_t st, st_nx;

  logic [IW-1:0]    idx;
  logic [SUM_W-1:0] acc;
  logic [DW-1:0]    diff;
  logic             more;

  assign more     = idx < IW'(DEPTH);
  assign diff     = (a_rdata >= b_rdata) ? a_rdata - b_rdata : b_rdata - a_rdata;
  assign mem_addr = idx[AW-1:0];

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (start) st_nx = S_INIT;
      S_INIT: st_nx = S_TEST;
      S_TEST: st_nx = more ? S_ACC : S_RES;
      S_ACC:  st_nx = S_TEST;
      S_RES:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      idx  <= '0;
      acc  <= '0;
      sad  <= '0;
      done <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= 1'b0;
      case (st)
        S_INIT: begin
          idx <= '0;
          acc <= '0;
        end
        S_ACC: begin
          acc <= acc + SUM_W'(diff);
          idx <= idx + 1'b1;
        end
        S_RES: begin
          sad  <= acc;
          done <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  p_idle_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !start) |=> (st == S_IDLE && !done));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_sad_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sad));
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (rst)
    idx <= IW'(DEPTH));
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_INIT) |=> (idx == '0 && acc == '0));
  p_step_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACC) |=> (idx == $past(idx) + 1'b1));
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_TEST) |=> $stable(mem_addr));
endmodule

// File: tb/sad_engine_tb.sv
module sad_engine_tb_top;
  localparam int DEPTH = 256;
  localparam int LAT   = 2 * DEPTH + 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  mem_addr;
  logic [7:0]  a_rdata, b_rdata;
  logic [15:0] sad;
  logic        done;
  logic [7:0]  mema [DEPTH];
  logic [7:0]  memb [DEPTH];
  int total = 0, bad = 0;
  bit wd_hit = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    a_rdata <= mema[mem_addr];
    b_rdata <= memb[mem_addr];
  end

  sad_engine dut_i (.clk(clk), .rst(rst), .start(start), .mem_addr(mem_addr),
    .a_rdata(a_rdata), .b_rdata(b_rdata), .sad(sad), .done(done));

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sum();
    int s = 0;
    for (int i = 0; i < DEPTH; i++)
      s += (mema[i] >= memb[i]) ? int'(mema[i]) - int'(memb[i]) : int'(memb[i]) - int'(mema[i]);
    return s;
  endfunction

  // returns cycles from start-sampling edge to done, -1 on timeout
  task automatic run(input int toggle_at, output int cyc);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    while (!done && cyc < LAT + 50) begin
      if (cyc == toggle_at) start = 1'b1;
      if (cyc == toggle_at + 3) start = 1'b0;
      @(negedge clk) cyc++;
    end
    if (!done) cyc = -1;
    start = 1'b0;
  endtask

  initial begin
    int cyc, exp, prev;
    for (int i = 0; i < DEPTH; i++) begin mema[i] = '0; memb[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", sad == 0 && done == 0, sad, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1", sad == 0 && done == 0, sad, 0);

    // R3 exhaustive over all byte pairs: A=i, B=i+k
    for (int k = 0; k < 256; k++) begin
      for (int i = 0; i < DEPTH; i++) begin
        mema[i] = 8'(i);
        memb[i] = 8'(i + k);
      end
      exp = ref_sum();
      run(-10, cyc);
      chk("R3", sad == 16'(exp), sad, exp);
      chk("R4", cyc == LAT, cyc, LAT);
      @(negedge clk);
      chk("R5", done == 0, done, 0);
    end

    // R2: idle with start low
    prev = sad;
    for (int i = 0; i < DEPTH; i++) mema[i] = 8'hff;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      chk("R2", done == 0 && sad == 16'(prev), sad, prev);
    end

    // R7: maximum total
    for (int i = 0; i < DEPTH; i++) begin mema[i] = 8'hff; memb[i] = 8'h00; end
    run(-10, cyc);
    chk("R7", sad == 16'd65280, sad, 65280);

    // R9: equal arrays after a maximum pass give zero
    for (int i = 0; i < DEPTH; i++) begin mema[i] = 8'(i * 7); memb[i] = 8'(i * 7); end
    run(-10, cyc);
    chk("R9", sad == 0, sad, 0);

    // R10: distinct bytes per address with reversed order
    for (int i = 0; i < DEPTH; i++) begin mema[i] = 8'(i); memb[i] = 8'(255 - i); end
    exp = ref_sum();
    run(-10, cyc);
    chk("R10", sad == 16'(exp), sad, exp);

    // R6: start pulsed mid-pass
    for (int i = 0; i < DEPTH; i++) begin mema[i] = 8'(i * 13 + 5); memb[i] = 8'(i * 3); end
    exp = ref_sum();
    run(100, cyc);
    chk("R6", sad == 16'(exp), sad, exp);
    chk("R6", cyc == LAT, cyc, LAT);

    // R8: start held high, successive pulses spaced by LAT
    @(negedge clk) start = 1'b1;
    cyc = 0;
    while (!done && cyc < LAT + 50) begin @(negedge clk); cyc++; end
    cyc = 0;
    @(negedge clk);
    while (!done && cyc < LAT + 50) begin @(negedge clk); cyc++; end
    start = 1'b0;
    chk("R8", cyc + 1 == LAT, cyc + 1, LAT);
    chk("R8", sad == 16'(exp), sad, exp);
    repeat (LAT + 10) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    wd_hit = 1'b1;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule